// File: doc/BRIEF.md
# Receive Clock-Source Lock Arbiter

This per-channel control block picks the frequency source for a clock-recovery loop. The loop can follow the incoming serial data stream, or it can fall back to the local reference clock. The block runs in the bit-clock domain and samples one recovered serial bit per cycle. It counts consecutive bit times that carry no transition, which gives a transition-density qualifier. That qualifier is combined with two flags produced outside the block: a signal-level-valid flag and a frequency-range-valid flag.

A qualification-enable control sets how strict the decision is:

- **Enable high:** level, range and density must all be good before the block selects data tracking.
- **Enable low:** only the range flag counts.

An active-low use-local-clock control overrides every qualifier and forces the reference clock. The block also drives an active-low link-fault output. That output is low whenever the reference clock is selected and high only while the data stream is being tracked.

Top module: `rxsel_lock_arb`

## Requirements
- R1: With `use_local_n` high and `qual_en` high, if `lvl_ok`, `rng_ok` and the density check are all good at a clock edge, `track_data` is 1 after that edge.
- R2: With `qual_en` high, a low `lvl_ok` or a low `rng_ok` at a clock edge makes `track_data` 0 after that edge. It stays 0 until all three qualifiers are good again.
- R3: The density check fails when the sampled bit equals its predecessor for 60 consecutive bit times. `track_data` then drops one edge after the density check fails. 59 such bits leave it tracking.
- R4: With `qual_en` low, only `rng_ok` decides `track_data`, one edge later. `lvl_ok` and the bit stream have no effect.
- R5: With `use_local_n` low at a clock edge, `track_data` is 0 after that edge, whatever the qualifiers are.
- R6: With `use_local_n` low at a clock edge, `link_fault_n` is 0 after that edge.
- R7: `link_fault_n` is 0 whenever the reference clock is selected and 1 whenever data tracking is selected, so it always equals `track_data`.
- R8: After synchronous reset, the outputs and internal state are as follows:
  - `track_data` is 0 and `link_fault_n` is 0.
  - The run counter is cleared and the density check reads failed.
  - The previous-bit register holds 0, so a constant-0 stream never passes the density check.
- R9: A single bit that differs from its predecessor restores the density check at that edge and restarts the run count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial bit, one per clock |
| lvl_ok | input | 1 | Signal level within limits |
| rng_ok | input | 1 | Loop frequency within range |
| qual_en | input | 1 | Enables the level and density qualifiers |
| use_local_n | input | 1 | Active-low force to the reference clock |
| track_data | output | 1 | 1 = follow data stream, 0 = reference clock |
| link_fault_n | output | 1 | Active-low link fault |

## Verification
On every cycle, the assertions check the following:
- The forced-local override of both outputs.
- The one-edge response to a level or range drop.
- The range-only decision when qualification is off.
- The rule that one transition restores density and that the run counter never passes its limit.

Only the bench's scenarios can show the following:
- The exact 59-versus-60 bit boundary of the density check, seen at the ports.
- The two-edge path from a bit pattern to `track_data`.
- The post-reset behaviour with a constant-zero stream.

// File: rtl/rxsel_pkg.sv
package rxsel_pkg;

    typedef enum logic {
        SRC_REF  = 1'b0,
        SRC_DATA = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic level;
        logic range;
        logic density;
    } qual_t;

    // Decide whether the qualifier set permits tracking the data stream.
    function automatic logic qual_pass(input qual_t q, input logic full_check);
        if (full_check)
            return q.level & q.range & q.density;
        else
            return q.range;
    endfunction

endpackage

// File: rtl/rxsel_density_mon.sv
module rxsel_density_mon #(
    parameter int RUN_LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic dens_ok
);
    localparam int CNT_W = $clog2(RUN_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(RUN_LIMIT);

    logic             prev_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_n;
    logic             ok_q;
    logic             ok_n;
    logic             edge_seen;

    assign edge_seen = (bit_in != prev_q);

    always_comb begin
        if (edge_seen) begin
            run_n = '0;
            ok_n  = 1'b1;
        end else begin
            run_n = (run_q == LIMIT_V) ? LIMIT_V : run_q + 1'b1;
            ok_n  = ok_q & (run_n != LIMIT_V);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            prev_q <= bit_in;
            run_q  <= run_n;
            ok_q   <= ok_n;
        end
    end

    assign dens_ok = ok_q;

    // R9
    edge_restores_chk: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> (dens_ok && run_q == '0));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= LIMIT_V);

    // R3
    limit_fails_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q == LIMIT_V) |-> !dens_ok);

endmodule

// File: rtl/rxsel_src_arb.sv
module rxsel_src_arb
    import rxsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qual_t    qual,
    input  logic     full_check,
    input  logic     use_local_n,
    output clk_src_e src_q,
    output logic     link_fault_n
);
    clk_src_e src_n;
    logic     fault_n_q;

    always_comb begin
        if (!use_local_n)
            src_n = SRC_REF;
        else if (qual_pass(qual, full_check))
            src_n = SRC_DATA;
        else
            src_n = SRC_REF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= SRC_REF;
            fault_n_q <= 1'b0;
        end else begin
            src_q     <= src_n;
            fault_n_q <= (src_n == SRC_DATA);
        end
    end

    assign link_fault_n = fault_n_q;

    // R5
    force_ref_chk: assert property (@(posedge clk) disable iff (rst)
        !use_local_n |=> (src_q == SRC_REF));

    // R6
    force_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !use_local_n |=> !link_fault_n);

    // R1
    all_good_track_chk: assert property (@(posedge clk) disable iff (rst)
        (use_local_n && full_check && qual.level && qual.range && qual.density)
        |=> (src_q == SRC_DATA));

    // R2
    qual_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full_check && (!qual.level || !qual.range)) |=> (src_q == SRC_REF));

    // R4
    range_only_chk: assert property (@(posedge clk) disable iff (rst)
        (use_local_n && !full_check) |=> ((src_q == SRC_DATA) == $past(qual.range)));

endmodule

// File: rtl/rxsel_lock_arb.sv
module rxsel_lock_arb
    import rxsel_pkg::*;
#(
    parameter int RUN_LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic lvl_ok,
    input  logic rng_ok,
    input  logic qual_en,
    input  logic use_local_n,
    output logic track_data,
    output logic link_fault_n
);
    logic     dens_ok;
    qual_t    qual;
    clk_src_e src;

    rxsel_density_mon #(
        .RUN_LIMIT(RUN_LIMIT)
    ) dens_i (
        .clk    (clk),
        .rst    (rst),
        .bit_in (rx_bit),
        .dens_ok(dens_ok)
    );

    always_comb begin
        qual.level   = lvl_ok;
        qual.range   = rng_ok;
        qual.density = dens_ok;
    end

    rxsel_src_arb arb_i (
        .clk         (clk),
        .rst         (rst),
        .qual        (qual),
        .full_check  (qual_en),
        .use_local_n (use_local_n),
        .src_q       (src),
        .link_fault_n(link_fault_n)
    );

    assign track_data = (src == SRC_DATA);

    // R7
    fault_tracks_sel_chk: assert property (@(posedge clk) disable iff (rst)
        link_fault_n == track_data);

endmodule

// File: tb/rxsel_lock_arb_tb_top.sv
module rxsel_lock_arb_tb_top;

    logic clk = 1'b0;
    logic rst, rx_bit, lvl_ok, rng_ok, qual_en, use_local_n;
    logic track_data, link_fault_n;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    rxsel_lock_arb #(.RUN_LIMIT(60)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_bit      (rx_bit),
        .lvl_ok      (lvl_ok),
        .rng_ok      (rng_ok),
        .qual_en     (qual_en),
        .use_local_n (use_local_n),
        .track_data  (track_data),
        .link_fault_n(link_fault_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one bit, then pass one rising edge; sampling happens at the negedge.
    task automatic cycle(input logic b);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; rx_bit = 1'b0;
        lvl_ok = 1'b1; rng_ok = 1'b1; qual_en = 1'b1; use_local_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 track after reset", track_data, 1'b0);
        chk("R8 fault after reset", link_fault_n, 1'b0);
        for (int i = 0; i < 8; i++) cycle(1'b0);
        chk("R8 constant-0 never passes density", track_data, 1'b0);
        chk("R7 fault equals select", link_fault_n, track_data);
    endtask

    task automatic t_all_good();
        do_reset();
        cycle(1'b1);
        cycle(1'b0);
        chk("R1 tracking with all qualifiers", track_data, 1'b1);
        chk("R7 fault high while tracking", link_fault_n, 1'b1);
    endtask

    task automatic t_qual_drop();
        logic b = 1'b0;
        do_reset();
        for (int i = 0; i < 4; i++) begin b = ~b; cycle(b); end
        chk("R1 toggling stream tracks", track_data, 1'b1);
        lvl_ok = 1'b0; b = ~b; cycle(b);
        chk("R2 level drop selects ref", track_data, 1'b0);
        chk("R7 fault low on ref", link_fault_n, 1'b0);
        b = ~b; cycle(b);
        chk("R2 ref held while level bad", track_data, 1'b0);
        lvl_ok = 1'b1; b = ~b; cycle(b);
        chk("R2 recovery when all valid", track_data, 1'b1);
        rng_ok = 1'b0; b = ~b; cycle(b);
        chk("R2 range drop selects ref", track_data, 1'b0);
        rng_ok = 1'b1; b = ~b; cycle(b);
        chk("R2 range recovery", track_data, 1'b1);
    endtask

    task automatic t_density();
        do_reset();
        cycle(1'b1);
        cycle(1'b0);
        for (int i = 0; i < 59; i++) cycle(1'b0);
        chk("R3 59 equal bits still tracking", track_data, 1'b1);
        cycle(1'b0);
        chk("R3 select lags density by one edge", track_data, 1'b1);
        cycle(1'b0);
        chk("R3 60 equal bits drop tracking", track_data, 1'b0);
        chk("R7 fault low after density fail", link_fault_n, 1'b0);
        cycle(1'b1);
        cycle(1'b1);
        chk("R9 one transition restores density", track_data, 1'b1);
        for (int i = 0; i < 58; i++) cycle(1'b1);
        chk("R9 run count restarted", track_data, 1'b1);
    endtask

    task automatic t_range_only();
        do_reset();
        qual_en = 1'b0; lvl_ok = 1'b0;
        for (int i = 0; i < 70; i++) cycle(1'b0);
        chk("R4 level and density ignored", track_data, 1'b1);
        rng_ok = 1'b0; cycle(1'b0);
        chk("R4 range low selects ref", track_data, 1'b0);
        rng_ok = 1'b1; cycle(1'b0);
        chk("R4 range high selects data", track_data, 1'b1);
    endtask

    task automatic t_force_local();
        logic b = 1'b0;
        do_reset();
        for (int i = 0; i < 3; i++) begin b = ~b; cycle(b); end
        chk("R1 tracking before override", track_data, 1'b1);
        use_local_n = 1'b0; b = ~b; cycle(b);
        chk("R5 override selects ref", track_data, 1'b0);
        chk("R6 override drives fault", link_fault_n, 1'b0);
        qual_en = 1'b0; b = ~b; cycle(b);
        chk("R5 override with range-only mode", track_data, 1'b0);
        chk("R6 fault held under override", link_fault_n, 1'b0);
        use_local_n = 1'b1; b = ~b; cycle(b);
        chk("R5 release returns to data", track_data, 1'b1);
        chk("R7 fault released with tracking", link_fault_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_all_good();
        t_qual_drop();
        t_density();
        t_range_only();
        t_force_local();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule